// File: doc/BRIEF.md
# Overclock Watchdog with Safe Frequency Fallback

This block supervises a programmable clock generator that may have been pushed past what the system can tolerate. Once armed, it measures a programmable interval in steps of 290 ms, built from a 1 ms tick. Any completed write from the configuration bus counts as a sign of life and restarts the interval. If the interval runs out without such a write, the block raises a sticky alarm. While the alarm holds, the frequency-select code sent to the synthesizer is replaced by a programmed safe code.

The safe code has five bits and uses the same encoding as the normal selection path. Bits 3..0 carry the four frequency-select lines and bit 4 carries the extra select bit. The block also forwards the request to take the frequency from the direct VCO divider registers. During an alarm this request is cancelled, so the safe table entry applies. Clearing the enable input disarms the watchdog and clears the alarm.

Top module: `wdt_safe_freq`

## Requirements
- R1: After reset, `alarmStatus` and `alarmPulse` are 0, `effSel` equals `curSel`, and `useVcoDiv` equals `vcoDirectReq`.
- R2: While `wdEnable` is 0, no alarm is raised, whatever ticks, services and count values arrive.
- R3: With `wdEnable` high and `wdCount` = C ≥ 1, `alarmStatus` rises at the clock edge after the one that accepts the (C·290)-th tick counted since the last restart.
- R4: Only clock cycles with `msTick` high advance the interval. Cycles without a tick leave the remaining time unchanged.
- R5: A cycle with `busWrite` high restarts the interval from `wdCount`. A tick in that same cycle is discarded, so C·290 fresh ticks are needed afterwards.
- R6: While the alarm is set, `effSel` equals `safeSel` (bit 4 is the extra select bit, bits 3..0 are the four frequency-select lines) and `useVcoDiv` is 0.
- R7: Once set, the alarm stays set while `wdEnable` stays high, regardless of ticks, `busWrite` or changes to `curSel`.
- R8: A cycle with `wdEnable` low clears `alarmStatus` at the next edge. The outputs then follow `curSel` and `vcoDirectReq` again.
- R9: With `wdCount` = 0, the alarm is set at the first clock edge that samples `wdEnable` high, with no tick needed.
- R10: `alarmPulse` is high for exactly the one cycle in which `alarmStatus` first reads 1 after being 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-cycle strobe per elapsed millisecond |
| wdEnable | input | 1 | Arms the watchdog; low disarms it and clears the alarm |
| wdCount | input | 8 | Interval length in 290 ms units |
| safeSel | input | 5 | Fallback frequency code: bit 4 extra select, bits 3..0 select lines |
| curSel | input | 5 | Frequency code chosen by the pins or the register |
| vcoDirectReq | input | 1 | Request to use the direct VCO divider values |
| busWrite | input | 1 | Strobe for a completed configuration write (service) |
| effSel | output | 5 | Frequency code applied to the synthesizer |
| useVcoDiv | output | 1 | Direct VCO divider values in use |
| alarmStatus | output | 1 | 0 = normal, 1 = alarm |
| alarmPulse | output | 1 | One-cycle strobe when the alarm is raised |

## Verification
Every state change is registered once. A tick, a service or an enable change sampled at one edge shows up on `alarmStatus` and `alarmPulse` just after that edge. The code outputs are combinational from the alarm register and the inputs, so they follow one cycle after the event that moved the alarm. The bench drives inputs at the falling edge and advances a reference model that counts remaining milliseconds directly. It compares all four outputs at the next falling edge, which is exactly one registered stage after the stimulus was sampled.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes from the control FSM to the counting datapath
  typedef struct packed {
    logic load;     // reload interval from count field, clear prescaler
    logic advance;  // accept one millisecond tick
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_dp.sv
module wdt_dp
  import wdt_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 290,
  parameter int CNT_W          = 8,
  parameter int SEL_W          = 5,
  parameter int RESET_UNITS    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wdtStrobe_t       strobe,
  input  logic [CNT_W-1:0] wdCount,
  input  logic             alarm,
  input  logic [SEL_W-1:0] curSel,
  input  logic [SEL_W-1:0] safeSel,
  input  logic             vcoDirectReq,
  output logic             remainZero,
  output logic [SEL_W-1:0] effSel,
  output logic             useVcoDiv
);
  localparam int PRE_W = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_UNIT - 1);

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] remainUnits;
  logic             preLast;

  assign preLast    = (preCnt == PRE_LAST);
  assign remainZero = (remainUnits == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preCnt      <= '0;
      remainUnits <= CNT_W'(RESET_UNITS);
    end else if (strobe.load) begin
      preCnt      <= '0;
      remainUnits <= wdCount;
    end else if (strobe.advance) begin
      if (preLast) begin
        preCnt      <= '0;
        remainUnits <= remainUnits - CNT_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  // Safe-code substitution while alarmed
  always_comb begin
    if (alarm) begin
      effSel    = safeSel;
      useVcoDiv = 1'b0;
    end else begin
      effSel    = curSel;
      useVcoDiv = vcoDirectReq;
    end
  end

  // Prescaler never passes its last state (R4)
  assert_pre_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    preCnt <= PRE_LAST);

  // No tick accepted and no reload: elapsed time frozen (R4)
  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.load && !strobe.advance) |=> ($stable(remainUnits) && $stable(preCnt)));

  // A full unit of ticks removes exactly one unit (R3)
  assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.load && strobe.advance && preLast) |=> (remainUnits == $past(remainUnits) - CNT_W'(1)));

  // Reload restores the programmed interval (R5)
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> (remainUnits == $past(wdCount) && preCnt == '0));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wdEnable,
  input  logic       busWrite,
  input  logic       msTick,
  input  logic       remainZero,
  output wdtStrobe_t strobe,
  output logic       alarm,
  output logic       alarmPulse
);
  logic armed;
  logic expire;

  assign armed  = wdEnable && !alarm;
  assign expire = armed && !busWrite && remainZero;

  always_comb begin
    strobe.load    = !wdEnable || (armed && busWrite);
    strobe.advance = armed && !busWrite && !remainZero && msTick;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm      <= 1'b0;
      alarmPulse <= 1'b0;
    end else if (!wdEnable) begin
      alarm      <= 1'b0;
      alarmPulse <= 1'b0;
    end else begin
      if (expire) alarm <= 1'b1;
      alarmPulse <= expire;
    end
  end

  // Disarming clears the alarm (R8, R2)
  assert_clear_on_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wdEnable |=> !alarm);

  // Alarm holds while enabled (R7)
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && wdEnable) |=> alarm);

  // Pulse only on the first alarm cycle (R10)
  assert_pulse_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alarmPulse |-> (alarm && !$past(alarm)));

  // Alarm rises only from an exhausted, armed interval (R3)
  assert_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(remainZero && wdEnable && !busWrite));

  // Exhausted interval alarms on the next edge (R9)
  assert_zero_alarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wdEnable && !alarm && !busWrite && remainZero) |=> (alarm && alarmPulse));

  // Strobes are never issued together with an alarm held (R7)
  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && wdEnable) |-> !strobe.advance && !strobe.load);
endmodule

// File: rtl/wdt_safe_freq.sv
module wdt_safe_freq
  import wdt_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 290,
  parameter int CNT_W          = 8,
  parameter int SEL_W          = 5,
  parameter int RESET_UNITS    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msTick,
  input  logic             wdEnable,
  input  logic [CNT_W-1:0] wdCount,
  input  logic [SEL_W-1:0] safeSel,
  input  logic [SEL_W-1:0] curSel,
  input  logic             vcoDirectReq,
  input  logic             busWrite,
  output logic [SEL_W-1:0] effSel,
  output logic             useVcoDiv,
  output logic             alarmStatus,
  output logic             alarmPulse
);
  wdtStrobe_t strobe;
  logic       remainZero;

  wdt_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wdEnable   (wdEnable),
    .busWrite   (busWrite),
    .msTick     (msTick),
    .remainZero (remainZero),
    .strobe     (strobe),
    .alarm      (alarmStatus),
    .alarmPulse (alarmPulse)
  );

  wdt_dp #(
    .TICKS_PER_UNIT (TICKS_PER_UNIT),
    .CNT_W          (CNT_W),
    .SEL_W          (SEL_W),
    .RESET_UNITS    (RESET_UNITS)
  ) dp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .wdCount      (wdCount),
    .alarm        (alarmStatus),
    .curSel       (curSel),
    .safeSel      (safeSel),
    .vcoDirectReq (vcoDirectReq),
    .remainZero   (remainZero),
    .effSel       (effSel),
    .useVcoDiv    (useVcoDiv)
  );
endmodule

// File: tb/wdt_safe_freq_tb_top.sv
module wdt_safe_freq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT_MS    = 290;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       msTick, wdEnable, vcoDirectReq, busWrite;
  logic [7:0] wdCount;
  logic [4:0] safeSel, curSel;
  logic [4:0] effSel;
  logic       useVcoDiv, alarmStatus, alarmPulse;

  int compared   = 0;
  int mismatched = 0;
  int cycles     = 0;
  bit finished   = 0;

  // Reference model: remaining milliseconds, not units
  bit mAlarm;
  bit mPulse;
  int mLeft;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_safe_freq dut_i (
    .clk(clk), .rst_n(rst_n), .msTick(msTick), .wdEnable(wdEnable),
    .wdCount(wdCount), .safeSel(safeSel), .curSel(curSel),
    .vcoDirectReq(vcoDirectReq), .busWrite(busWrite),
    .effSel(effSel), .useVcoDiv(useVcoDiv),
    .alarmStatus(alarmStatus), .alarmPulse(alarmPulse)
  );

  function automatic logic [4:0] expSel();
    return mAlarm ? safeSel : curSel;
  endfunction

  function automatic logic expVco();
    return mAlarm ? 1'b0 : vcoDirectReq;
  endfunction

  task automatic modelStep();
    if (!wdEnable) begin
      mAlarm = 0; mPulse = 0; mLeft = int'(wdCount) * UNIT_MS;
    end else if (mAlarm) begin
      mPulse = 0;
    end else if (busWrite) begin
      mPulse = 0; mLeft = int'(wdCount) * UNIT_MS;
    end else if (mLeft == 0) begin
      mAlarm = 1; mPulse = 1;
    end else begin
      mPulse = 0;
      if (msTick) mLeft = mLeft - 1;
    end
  endtask

  task automatic checkOne(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cycles);
    end
  endtask

  task automatic compareAll(string tag);
    checkOne(tag, "alarmStatus", int'(alarmStatus), int'(mAlarm));
    checkOne(tag, "alarmPulse",  int'(alarmPulse),  int'(mPulse));
    checkOne(tag, "effSel",      int'(effSel),      int'(expSel()));
    checkOne(tag, "useVcoDiv",   int'(useVcoDiv),   int'(expVco()));
  endtask

  // Inputs already set at a falling edge; advance one clock and compare
  task automatic step(string tag);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    compareAll(tag);
  endtask

  task automatic setIn(bit en, bit svc, bit tk, logic [7:0] cnt);
    wdEnable = en; busWrite = svc; msTick = tk; wdCount = cnt;
  endtask

  initial begin : watchdog_timer
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired before the run finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stimulus
    void'($urandom(32'h5A17));
    rst_n = 1'b0;
    setIn(0, 0, 0, 8'd16);
    safeSel = 5'b10110; curSel = 5'b00011; vcoDirectReq = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mAlarm = 0; mPulse = 0; mLeft = 16 * UNIT_MS;
    // R1: reset state
    compareAll("R1");

    // R2: disabled, heavy ticks and services, varying codes
    for (int i = 0; i < 1500; i++) begin
      setIn(0, ($urandom % 7) == 0, 1, 8'($urandom % 3));
      curSel = 5'($urandom); vcoDirectReq = 1'($urandom);
      step("R2");
    end

    // R3, R6, R10: count 2, tick every cycle -> alarm after 580 ticks
    curSel = 5'b01001; safeSel = 5'b10101; vcoDirectReq = 1'b1;
    setIn(0, 0, 0, 8'd2); step("R3");
    for (int i = 0; i < 2 * UNIT_MS + 3; i++) begin
      setIn(1, 0, 1, 8'd2);
      step(i >= 2 * UNIT_MS ? "R6" : "R3");
    end
    checkOne("R3", "alarm after 580 ticks", int'(alarmStatus), 1);
    checkOne("R6", "safe code applied", int'(effSel), int'(5'b10101));

    // R7: sticky through ticks, services and code changes
    for (int i = 0; i < 400; i++) begin
      setIn(1, ($urandom % 4) == 0, 1, 8'($urandom % 3));
      curSel = 5'($urandom); vcoDirectReq = 1'b1;
      step("R7");
    end

    // R8: one disabled cycle clears it
    setIn(0, 0, 1, 8'd1); step("R8");
    checkOne("R8", "cleared", int'(alarmStatus), 0);
    checkOne("R8", "vco restored", int'(useVcoDiv), 1);

    // R4: count 1, one tick in three cycles
    for (int i = 0; i < 3 * UNIT_MS + 10; i++) begin
      setIn(1, 0, (i % 3) == 2, 8'd1);
      step("R4");
    end
    checkOne("R4", "alarm after sparse ticks", int'(alarmStatus), 1);
    setIn(0, 0, 0, 8'd1); step("R8");

    // R5: services every 200 ticks keep it quiet, tick during service discarded
    for (int i = 0; i < 800; i++) begin
      setIn(1, (i % 200) == 199, 1, 8'd1);
      step("R5");
    end
    checkOne("R5", "no alarm while serviced", int'(alarmStatus), 0);
    for (int i = 0; i < UNIT_MS + 2; i++) begin
      setIn(1, 0, 1, 8'd1);
      step("R5");
    end
    checkOne("R5", "alarm after service stops", int'(alarmStatus), 1);
    setIn(0, 0, 0, 8'd0); step("R8");

    // R9: zero count alarms at the first enabled edge, no tick
    setIn(1, 0, 0, 8'd0); step("R9");
    checkOne("R9", "immediate alarm", int'(alarmStatus), 1);
    checkOne("R10", "pulse on entry", int'(alarmPulse), 1);
    step("R10");
    checkOne("R10", "pulse one cycle", int'(alarmPulse), 0);
    setIn(0, 0, 0, 8'd0); step("R8");

    // Constrained random mix
    for (int i = 0; i < 6000; i++) begin
      setIn(($urandom % 50) != 0, ($urandom % 300) == 0, ($urandom % 2) == 0,
            8'($urandom % 4));
      curSel = 5'($urandom); safeSel = 5'($urandom); vcoDirectReq = 1'($urandom);
      step("R3");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule